// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a bus-attached watchdog. An up-counter steps on a slow functional tick. A prescaler can divide that tick by a power of two. When the counter rolls over from all ones to zero while the watchdog is armed, the block raises a reset request for one clock. It then restarts the count from the load value.

Software controls the watchdog only through keyed writes. Two fixed 16-bit words, written in order to the key register, arm the counter. A different pair disarms it. Software keeps the system alive by writing the trigger register with a value that differs from the previous one. Each such write copies the load value into the counter.

Every write to the control, load, trigger or key register is posted. The write raises its own pending flag and takes effect a fixed number of tick periods later. The slow clock domain is represented by the tick-enable input `tick_i`.

Top module: `kwdt_top`

## Requirements
- R1: After reset the counter, load value, control fields, configuration bit, pending flags and reset request are all zero, and the watchdog is disarmed.
- R2: Register word addresses are control 0, load 1, counter 2 (read only), trigger 3, key 4 (reads armed state in bit 0), pending 5 (read only) and configuration 6. A posted write sets its pending bit at once: bit 0 for control, bit 2 for load, bit 3 for trigger, bit 4 for key. The bit clears in the same cycle that the write takes effect, on the fourth `tick_i` cycle after the write is accepted.
- R3: A write to a register whose pending bit is set is dropped, and the first value still lands.
- R4: The watchdog arms only after 0xBBBB and then 0x4444 take effect on the key register (low 16 bits compared). The first word alone does not arm it.
- R5: The watchdog disarms only after 0xAAAA and then 0x5555 take effect on the key register. While disarmed, the counter holds except on a refresh.
- R6: If the second key word does not follow its first word, the sequence returns to idle and the armed state is kept. A later second word alone then has no effect.
- R7: While armed, the counter counts up by one per step. In the control register, bit 5 enables the prescaler and bits 4:2 hold N. With the prescaler on, a step occurs once every 2^N ticks; with it off, a step occurs on every tick. Applying a control write restarts the prescaler phase.
- R8: A trigger write whose value differs from the last applied trigger value loads the counter from the load register, taking priority over a step in the same cycle. An equal value does not reload.
- R9: A step from all ones while armed loads the counter from the load register and drives `rst_req_o` high for exactly one clock, in the cycle after that step.
- R10: Configuration bit 0 is stored and read back immediately, with no pending flag, and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable marking a slow functional tick |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| rst_req_o | output | 1 | One-clock reset request on rollover |

## Verification
A wrong key-sequence state shows up on the key register's armed bit, four ticks after the second word is posted. From then on the counter either keeps stepping or stops on the next tick. A wrong posting counter or pending flag appears on the pending register in the cycle after a write, or as a value that lands one tick early or late. Prescaler or refresh faults appear as a counter value that is off by one step within a few ticks. A bad rollover produces a missing pulse or a pulse wider than one clock on `rst_req_o`, in the cycle after the step from all ones.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_LOAD = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TRIG = 3'd3;
  localparam logic [ADDR_W-1:0] A_KEY  = 3'd4;
  localparam logic [ADDR_W-1:0] A_PEND = 3'd5;
  localparam logic [ADDR_W-1:0] A_SYS  = 3'd6;

  localparam logic [15:0] KEY_ARM_1 = 16'hBBBB;
  localparam logic [15:0] KEY_ARM_2 = 16'h4444;
  localparam logic [15:0] KEY_DIS_1 = 16'hAAAA;
  localparam logic [15:0] KEY_DIS_2 = 16'h5555;

  localparam int NSLOT  = 4;
  localparam int S_CTRL = 0;
  localparam int S_LOAD = 1;
  localparam int S_TRIG = 2;
  localparam int S_KEY  = 3;

  typedef enum logic [1:0] {K_IDLE, K_ARM1, K_DIS1} key_st_e;
endpackage

// File: rtl/kwdt_post.sv
module kwdt_post #(
  parameter int DATA_W     = 32,
  parameter int SYNC_TICKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pend_o,
  output logic              fire_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CW = $clog2(SYNC_TICKS + 1);

  logic [CW-1:0]     cnt_q;
  logic              pend_q;
  logic [DATA_W-1:0] data_q;

  assign fire_o = pend_q && tick_i && (cnt_q == CW'(SYNC_TICKS - 1));
  assign pend_o = pend_q;
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else if (wr_i && !pend_q) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
      data_q <= wdata_i;
    end else if (pend_q && tick_i) begin
      if (fire_o) pend_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fire_i,
  input  logic [15:0] word_i,
  output logic        armed_o
);
  key_st_e st_q;
  logic    armed_q;

  assign armed_o = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= K_IDLE;
      armed_q <= 1'b0;
    end else if (fire_i) begin
      unique case (st_q)
        K_IDLE: begin
          if (word_i == KEY_ARM_1)      st_q <= K_ARM1;
          else if (word_i == KEY_DIS_1) st_q <= K_DIS1;
        end
        K_ARM1: begin
          if (word_i == KEY_ARM_2) armed_q <= 1'b1;
          st_q <= K_IDLE;
        end
        K_DIS1: begin
          if (word_i == KEY_DIS_2) armed_q <= 1'b0;
          st_q <= K_IDLE;
        end
        default: st_q <= K_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pre_en_i,
  input  logic [2:0]       ptv_i,
  input  logic             psc_clr_i,
  input  logic             armed_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             adv_o,
  output logic             wrap_o
);
  logic [PSC_W-1:0] psc_q, psc_lim;
  logic [CNT_W-1:0] count_q;

  assign psc_lim = PSC_W'((1 << ptv_i) - 1);
  assign adv_o   = tick_i && (!pre_en_i || psc_q == psc_lim);
  assign wrap_o  = armed_i && adv_o && !reload_i && (&count_q);
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psc_q <= '0;
    else if (psc_clr_i) psc_q <= '0;
    else if (tick_i && pre_en_i) psc_q <= (psc_q == psc_lim) ? '0 : psc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else if (reload_i || wrap_o) count_q <= load_i;
    else if (armed_i && adv_o) count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int SYNC_TICKS = 4,
  parameter int PSC_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  localparam logic [ADDR_W-1:0] SLOT_ADDR [NSLOT] = '{A_CTRL, A_LOAD, A_TRIG, A_KEY};

  logic [NSLOT-1:0]  pend, fire;
  logic [DATA_W-1:0] sdata [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    kwdt_post #(.DATA_W(DATA_W), .SYNC_TICKS(SYNC_TICKS)) u_post (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .wr_i    (we_i && addr_i == SLOT_ADDR[g]),
      .wdata_i (wdata_i),
      .pend_o  (pend[g]),
      .fire_o  (fire[g]),
      .data_o  (sdata[g])
    );
  end

  logic              pre_en_q, sys_q, armed, refresh, adv, wrap, rst_req_q;
  logic [2:0]        ptv_q;
  logic [CNT_W-1:0]  load_q, count;
  logic [DATA_W-1:0] last_trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_en_q    <= 1'b0;
      ptv_q       <= '0;
      load_q      <= '0;
      last_trig_q <= '0;
      sys_q       <= 1'b0;
      rst_req_q   <= 1'b0;
    end else begin
      if (fire[S_CTRL]) begin
        pre_en_q <= sdata[S_CTRL][5];
        ptv_q    <= sdata[S_CTRL][4:2];
      end
      if (fire[S_LOAD]) load_q <= sdata[S_LOAD][CNT_W-1:0];
      if (fire[S_TRIG]) last_trig_q <= sdata[S_TRIG];
      if (we_i && addr_i == A_SYS) sys_q <= wdata_i[0];
      rst_req_q <= wrap;
    end
  end

  // refresh only on a changed trigger value
  assign refresh = fire[S_TRIG] && (sdata[S_TRIG] != last_trig_q);

  kwdt_keyseq u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire[S_KEY]),
    .word_i  (sdata[S_KEY][15:0]),
    .armed_o (armed)
  );

  kwdt_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .pre_en_i  (pre_en_q),
    .ptv_i     (ptv_q),
    .psc_clr_i (fire[S_CTRL]),
    .armed_i   (armed),
    .reload_i  (refresh),
    .load_i    (load_q),
    .count_o   (count),
    .adv_o     (adv),
    .wrap_o    (wrap)
  );

  assign rst_req_o = rst_req_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o[5:2] = {pre_en_q, ptv_q};
      A_LOAD: rdata_o = DATA_W'(load_q);
      A_CNT:  rdata_o = DATA_W'(count);
      A_TRIG: rdata_o = last_trig_q;
      A_KEY:  rdata_o[0] = armed;
      A_PEND: rdata_o[4:0] = {pend[S_KEY], pend[S_TRIG], pend[S_LOAD], 1'b0, pend[S_CTRL]};
      A_SYS:  rdata_o[0] = sys_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             rst_req_o,
  input logic             armed_i,
  input logic             adv_i,
  input logic             refresh_i,
  input logic [CNT_W-1:0] count_i,
  input logic [3:0]       pend_i
);
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  a_r9_pulse_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(armed_i));

  a_r9_wrap_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && adv_i && !refresh_i && (&count_i)) |=> rst_req_o);

  a_r5_disarmed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_i && !refresh_i) |=> $stable(count_i));

  a_r7_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && adv_i && !refresh_i && !(&count_i)) |=> count_i == $past(count_i) + 1'b1);

  a_r2_pend_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ((pend_i & $past(pend_i)) == $past(pend_i)));
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .rst_req_o (rst_req_o),
  .armed_i   (armed),
  .adv_i     (adv),
  .refresh_i (refresh),
  .count_i   (count),
  .pend_i    (pend)
);

// File: tb/kwdt_top_tb_top.sv
`timescale 1ns/1ps
module kwdt_top_tb_top;
  import kwdt_pkg::*;

  logic              clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              rst_req_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  kwdt_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o), .rst_req_o(rst_req_o)
  );

  typedef struct packed {
    logic [2:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [4:0]  pm;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{3'd0, 32'h0000_003C, 32'h0000_003C, 5'h01},
    '{3'd1, 32'h0000_0010, 32'h0000_0010, 5'h04},
    '{3'd6, 32'h0000_0001, 32'h0000_0001, 5'h00},
    '{3'd0, 32'h0000_0000, 32'h0000_0000, 5'h01}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr_i = a; #1; v = rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic rchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic post(input logic [2:0] a, input logic [31:0] d);
    wr(a, d);
    ticks(4);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rchk("R1 count", A_CNT, 32'h0);
    rchk("R1 pend", A_PEND, 32'h0);
    rchk("R1 armed", A_KEY, 32'h0);
    rchk("R1 ctrl", A_CTRL, 32'h0);
    rchk("R1 load", A_LOAD, 32'h0);
    chk("R1 rst_req", {31'b0, rst_req_o}, 32'h0);

    // R2 / R10 vector table
    foreach (VECS[i]) begin
      wr(VECS[i].a, VECS[i].d);
      rchk("R2 pend set", A_PEND, {27'b0, VECS[i].pm});
      if (VECS[i].pm != 0) begin
        ticks(3);
        rchk("R2 pend held", A_PEND, {27'b0, VECS[i].pm});
        ticks(1);
        rchk("R2 pend clear", A_PEND, 32'h0);
      end
      rchk("R2 R10 readback", VECS[i].a, VECS[i].exp);
    end

    // R3 write while pending dropped
    wr(A_LOAD, 32'h20);
    wr(A_LOAD, 32'h30);
    ticks(4);
    rchk("R3 load", A_LOAD, 32'h20);
    rchk("R3 pend", A_PEND, 32'h0);

    // R8 refresh when disarmed
    post(A_TRIG, 32'h1234);
    rchk("R8 reload", A_CNT, 32'h20);
    post(A_LOAD, 32'h40);
    post(A_TRIG, 32'h1234);
    rchk("R8 same value no reload", A_CNT, 32'h20);
    post(A_TRIG, 32'hEDCB);
    rchk("R8 new value reload", A_CNT, 32'h40);

    // R4 arm
    post(A_KEY, 32'hBBBB);
    rchk("R4 first word only", A_KEY, 32'h0);
    post(A_KEY, 32'h4444);
    rchk("R4 armed", A_KEY, 32'h1);
    rchk("R4 count", A_CNT, 32'h40);
    ticks(5);
    rchk("R7 R10 step per tick, cfg bit set", A_CNT, 32'h45);

    // R7 prescaler 2^2
    post(A_CTRL, 32'h28);
    rchk("R7 ctrl apply", A_CNT, 32'h49);
    ticks(8);
    rchk("R7 div4 two steps", A_CNT, 32'h4B);
    ticks(3);
    rchk("R7 div4 no step", A_CNT, 32'h4B);
    ticks(1);
    rchk("R7 div4 step", A_CNT, 32'h4C);
    post(A_CTRL, 32'h0);
    rchk("R7 ctrl off", A_CNT, 32'h4D);

    // R6 broken disarm sequence
    post(A_KEY, 32'hAAAA);
    rchk("R6 count", A_CNT, 32'h51);
    post(A_KEY, 32'h1234);
    rchk("R6 still armed", A_KEY, 32'h1);
    post(A_KEY, 32'h5555);
    rchk("R6 lone second word", A_KEY, 32'h1);
    rchk("R6 count after", A_CNT, 32'h59);

    // R8 priority and R9 rollover
    post(A_LOAD, 32'hFFFF_FFFD);
    post(A_TRIG, 32'h5A5A);
    rchk("R8 refresh over step", A_CNT, 32'hFFFF_FFFD);
    ticks(2);
    rchk("R9 at max", A_CNT, 32'hFFFF_FFFF);
    chk("R9 no early pulse", {31'b0, rst_req_o}, 32'h0);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    chk("R9 pulse", {31'b0, rst_req_o}, 32'h1);
    rchk("R9 reload", A_CNT, 32'hFFFF_FFFD);
    @(negedge clk);
    chk("R9 pulse width", {31'b0, rst_req_o}, 32'h0);

    // R5 disarm
    post(A_KEY, 32'hAAAA);
    post(A_KEY, 32'h5555);
    rchk("R5 disarmed", A_KEY, 32'h0);
    rchk("R5 count", A_CNT, 32'hFFFF_FFFF);
    ticks(3);
    rchk("R5 hold", A_CNT, 32'hFFFF_FFFF);
    chk("R5 no pulse", {31'b0, rst_req_o}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule